// File: doc/BRIEF.md
# Weight-Stationary Convolution Row

This block computes one output row of a one-dimensional convolution on a chain of K multiply-accumulate processing elements. Each element holds one filter tap in a local register. That tap is reused for every activation of every row until new weights are loaded. Each accepted activation goes to all K elements in the same cycle. Each element adds its product to the running sum handed over by its lower neighbour and registers the result. A given output position therefore collects the product with tap k from element k, one cycle after it collected the product with tap k-1.

Weights are loaded before streaming starts. They go in serially through a shift-in port while a load strobe is held high. Activations then stream in one per accepted cycle, and a row-start flag marks the first activation of each row. A partial sum from an earlier activation row can come in beside any activation. It is added to the output position that begins at that activation, so a 2D convolution can be built up one row at a time. Each result leaves with a valid strobe. The host treats it either as the finished sum or as a partial sum to send back in with the next activation row.

Top module: `ws_conv_row`

## Requirements
- R1: Weight loading shifts serially. Each cycle with `w_load` high moves every tap k to tap k+1 and writes `w_in` into tap 0. After K load cycles, the value written first sits in tap K-1 and the value written last sits in tap 0.
- R2: Let a row's accepted activations be x[0], x[1] and so on. Output position j is p[j] + sum over k of w[k]*x[j+k]. All operands are signed two's complement: 8-bit data, and products sign-extended to 24 bits. The sum wraps modulo 2^24.
- R3: `out_valid` is high for exactly the cycle after an accepted activation whose row index is K-1 or more. With that activation, `out_sum` carries position (index - K + 1). The first K-1 activations of a row produce no result.
- R4: An accepted activation with `act_first` high gets row index 0. Sums still in flight from the earlier row never appear as a valid result. This holds even when that row was shorter than K.
- R5: When `psum_en` is high with an accepted activation at row index j, `psum_in` is the p[j] of position j. When `psum_en` is low, p[j] is zero.
- R6: A cycle without an accepted activation changes no state. In the next cycle `out_valid` is low and `out_sum` holds its value. The row then carries on as if the idle cycle had not happened.
- R7: While `w_load` is high, `act_valid` is ignored. No activation is accepted, the row index and running sums do not move, and `out_valid` is low in the next cycle.
- R8: Reset clears all taps, running sums and the row index to zero. `out_valid` and `out_sum` are zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_load | input | 1 | Shift `w_in` into tap 0 this cycle |
| w_in | input | DW | Serial weight value |
| act_valid | input | 1 | Activation present this cycle |
| act_first | input | 1 | Activation is index 0 of a new row |
| act_data | input | DW | Activation, broadcast to all taps |
| psum_en | input | 1 | Add `psum_in` to the position starting here |
| psum_in | input | AW | Partial sum carried from an earlier row |
| out_valid | output | 1 | `out_sum` holds a new row result |
| out_sum | output | AW | Final or partial sum for one output position |

## Verification
A tap in the wrong place, or a lost load shift, shows up in the first valid result after loading as a sum that uses the wrong weight. A corrupted running sum inside the chain reaches `out_sum` within at most K accepted activations. After that it has either left the chain or been overwritten. A wrong row index shows up at once as a valid strobe that is too early, too late or missing: this is checked at every row start, after every idle cycle and during every load cycle.

// File: rtl/ws_conv_pkg.sv
package ws_conv_pkg;
  localparam int DEF_TAPS = 5;
  localparam int DEF_DW   = 8;
  localparam int DEF_AW   = 24;
endpackage

// File: rtl/ws_weight_bank.sv
module ws_weight_bank #(
  parameter int K  = ws_conv_pkg::DEF_TAPS,
  parameter int DW = ws_conv_pkg::DEF_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   w_in,
  output logic [K*DW-1:0] taps
);
  logic [K*DW-1:0] taps_q;
  logic [K*DW-1:0] taps_nxt;

  for (genvar i = 0; i < K; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_comb taps_nxt[DW-1:0] = load ? w_in : taps_q[DW-1:0];
    end else begin : g_body
      always_comb
        taps_nxt[i*DW +: DW] = load ? taps_q[(i-1)*DW +: DW] : taps_q[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_nxt;
  end

  assign taps = taps_q;
endmodule

// File: rtl/ws_mac_pe.sv
module ws_mac_pe #(
  parameter int DW = ws_conv_pkg::DEF_DW,
  parameter int AW = ws_conv_pkg::DEF_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] weight,
  input  logic signed [DW-1:0] act,
  input  logic signed [AW-1:0] acc_in,
  output logic signed [AW-1:0] acc_out
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nxt;

  always_comb begin
    prod     = weight * act;
    prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    acc_nxt  = en ? (acc_in + prod_ext) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/ws_row_seq.sv
module ws_row_seq #(
  parameter int K = ws_conv_pkg::DEF_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic first,
  output logic res_valid
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_cur;
  logic [CW-1:0] idx_nxt;
  logic          vld_q;
  logic          vld_nxt;
  logic          hit;

  always_comb begin
    idx_cur = first ? '0 : idx_q;
    hit     = (idx_cur == LAST);
    idx_nxt = idx_q;
    if (adv) idx_nxt = hit ? LAST : (idx_cur + CW'(1));
    vld_nxt = adv & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign res_valid = vld_q;
endmodule

// File: rtl/ws_conv_row.sv
module ws_conv_row #(
  parameter int K  = ws_conv_pkg::DEF_TAPS,
  parameter int DW = ws_conv_pkg::DEF_DW,
  parameter int AW = ws_conv_pkg::DEF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_load,
  input  logic [DW-1:0] w_in,
  input  logic          act_valid,
  input  logic          act_first,
  input  logic [DW-1:0] act_data,
  input  logic          psum_en,
  input  logic [AW-1:0] psum_in,
  output logic          out_valid,
  output logic [AW-1:0] out_sum
);
  logic                 adv;
  logic [K*DW-1:0]      taps;
  logic signed [AW-1:0] chain [K+1];

  assign adv      = act_valid & ~w_load;
  assign chain[0] = psum_en ? $signed(psum_in) : '0;

  ws_weight_bank #(.K(K), .DW(DW)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (w_load),
    .w_in (w_in),
    .taps (taps)
  );

  for (genvar i = 0; i < K; i++) begin : g_pe
    ws_mac_pe #(.DW(DW), .AW(AW)) u_pe (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (adv),
      .weight ($signed(taps[i*DW +: DW])),
      .act    ($signed(act_data)),
      .acc_in (chain[i]),
      .acc_out(chain[i+1])
    );
  end

  ws_row_seq #(.K(K)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .first    (act_first),
    .res_valid(out_valid)
  );

  assign out_sum = chain[K];
endmodule

// File: rtl/ws_conv_row_chk.sv
module ws_conv_row_chk #(
  parameter int K  = ws_conv_pkg::DEF_TAPS,
  parameter int AW = ws_conv_pkg::DEF_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          w_load,
  input logic          act_valid,
  input logic          act_first,
  input logic          out_valid,
  input logic [AW-1:0] out_sum
);
  logic accepted;
  assign accepted = act_valid && !w_load;

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!out_valid && out_sum == '0) else $error("reset state"); // R8

  AST_VALID_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accepted)) else $error("valid without activation"); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> (!out_valid && $stable(out_sum))) else $error("idle cycle moved output"); // R6

  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> !out_valid) else $error("result during load"); // R7

  if (K > 1) begin : g_first
    AST_ROW_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && act_first) |=> !out_valid) else $error("result at row start"); // R4
  end
endmodule

bind ws_conv_row ws_conv_row_chk #(.K(K), .AW(AW)) u_chk (.*);

// File: tb/ws_conv_row_bench.sv
module ws_conv_row_bench;
  localparam int K  = 5;
  localparam int DW = 8;
  localparam int AW = 24;
  localparam int NV = 20;

  // {first, psum_en, act, psum}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h05, 24'h000010},
    {1'b0, 1'b0, 8'hFD, 24'h000000},
    {1'b0, 1'b1, 8'h7F, 24'hFFFFF0},
    {1'b0, 1'b0, 8'h80, 24'h000000},
    {1'b0, 1'b1, 8'h11, 24'h000100},
    {1'b0, 1'b0, 8'hC3, 24'h000000},
    {1'b0, 1'b1, 8'h2A, 24'h000003},
    {1'b0, 1'b0, 8'h01, 24'h000000},
    {1'b1, 1'b0, 8'h44, 24'h000000},
    {1'b0, 1'b0, 8'h55, 24'h000000},
    {1'b1, 1'b1, 8'h7F, 24'h7FFFFF},
    {1'b0, 1'b0, 8'h7F, 24'h000000},
    {1'b0, 1'b0, 8'h7F, 24'h000000},
    {1'b0, 1'b0, 8'h7F, 24'h000000},
    {1'b0, 1'b0, 8'h7F, 24'h000000},
    {1'b0, 1'b1, 8'h80, 24'h800000},
    {1'b0, 1'b0, 8'h80, 24'h000000},
    {1'b0, 1'b1, 8'hFF, 24'h000001},
    {1'b0, 1'b0, 8'h00, 24'h000000},
    {1'b0, 1'b0, 8'h09, 24'h000000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          w_load, act_valid, act_first, psum_en;
  logic [DW-1:0] w_in, act_data;
  logic [AW-1:0] psum_in;
  logic          out_valid;
  logic [AW-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int wts [K];
  int hx [0:1023];
  int hp [0:1023];
  int row_n = 0;
  logic [AW-1:0] last_sum = '0;

  always #5 clk = ~clk;

  ws_conv_row #(.K(K), .DW(DW), .AW(AW)) u_ws_conv_row (.*);

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit f, input bit pe, input logic [DW-1:0] x,
                      input logic [AW-1:0] p, input bit ld, input logic [DW-1:0] wi, input string req);
    bit acc;
    int sum;
    int j;
    act_valid = v; act_first = f; psum_en = pe; act_data = x; psum_in = p;
    w_load = ld; w_in = wi;
    acc = v && !ld;
    if (ld) begin
      for (int k = K - 1; k > 0; k--) wts[k] = wts[k-1];
      wts[0] = $signed(wi);
    end
    if (acc) begin
      if (f) row_n = 0;
      hx[row_n] = $signed(x);
      hp[row_n] = pe ? $signed(p) : 0;
      row_n++;
    end
    @(negedge clk);
    if (acc && row_n >= K) begin
      j = row_n - K;
      sum = hp[j];
      for (int k = 0; k < K; k++) sum += wts[k] * hx[j+k];
      check(out_valid === 1'b1, req, {23'd0, out_valid}, 24'd1);
      check(out_sum === sum[AW-1:0], req, out_sum, sum[AW-1:0]);
    end else begin
      check(out_valid === 1'b0, req, {23'd0, out_valid}, 24'd0);
      if (!acc) check(out_sum === last_sum, req, out_sum, last_sum);
    end
    last_sum = out_sum;
    act_valid = 0; w_load = 0;
  endtask

  task automatic load_set(input int w0, input int w1, input int w2, input int w3, input int w4);
    int ws [K];
    ws = '{w0, w1, w2, w3, w4};
    for (int k = K - 1; k >= 0; k--) step(1'b0, 1'b0, 1'b0, 8'h00, '0, 1'b1, ws[k][DW-1:0], "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < K; k++) wts[k] = 0;
    rst_n = 0; w_load = 0; w_in = '0; act_valid = 0; act_first = 0;
    act_data = '0; psum_in = '0; psum_en = 0;
    @(negedge clk); @(negedge clk);
    // R8: reset state
    check(out_valid === 1'b0, "R8", {23'd0, out_valid}, 24'd0);
    check(out_sum === '0, "R8", out_sum, '0);
    rst_n = 1;
    // R8: taps cleared, so results equal the carried partial sums
    for (int i = 0; i < 7; i++)
      step(1'b1, i == 0, 1'b1, 8'(i * 37 + 3), 24'(i * 1000 + 7), 1'b0, 8'h00, "R8");

    // R1: serial load of taps 3,-2,5,1,-4
    load_set(3, -2, 5, 1, -4);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < NV; i++)
      step(1'b1, VEC[i][33], VEC[i][32], VEC[i][31:24], VEC[i][23:0], 1'b0, 8'h00, "R2");

    // R6: idle cycles inside a row leave output held
    step(1'b1, 1'b1, 1'b1, 8'h10, 24'h000020, 1'b0, 8'h00, "R6");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h21 + i), '0, 1'b0, 8'h00, "R6");
      step(1'b0, 1'b0, 1'b0, 8'hEE, 24'h123456, 1'b0, 8'h00, "R6");
    end

    // R7: reload the same taps with act_valid high mid-row, row must continue intact
    step(1'b1, 1'b1, 1'b0, 8'h07, '0, 1'b0, 8'h00, "R7");
    step(1'b1, 1'b0, 1'b0, 8'hF9, '0, 1'b0, 8'h00, "R7");
    begin
      int keep [K];
      keep = wts;
      for (int k = K - 1; k >= 0; k--) step(1'b1, 1'b0, 1'b0, 8'h5A, '0, 1'b1, keep[k][DW-1:0], "R7");
    end
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 8'(i * 19 - 40), '0, 1'b0, 8'h00, "R7");

    // R2 R5: random taps and rows against the behavioural convolution
    for (int r = 0; r < 4; r++) begin
      load_set($signed(8'($urandom)), $signed(8'($urandom)), $signed(8'($urandom)),
               $signed(8'($urandom)), $signed(8'($urandom)));
      for (int i = 0; i < 14; i++)
        step(1'b1, i == 0, 1'($urandom), 8'($urandom), 24'($urandom), 1'b0, 8'h00, "R2");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule